// File: doc/BRIEF.md
# Paired-Access Register File

This block is a 32-word by 32-bit integer register file for a 32-bit core that keeps 64-bit accumulators in two neighbouring registers. Besides two ordinary 32-bit read ports it has two 64-bit pair read ports and one 64-bit pair write port. A pair is named by a 5-bit register field whose upper four bits give the pair number d. The pair covers register 2d, which carries bits 31:0, and register 2d+1, which carries bits 63:32. The lowest bit of the field plays no part.

A multiply-accumulate unit drives the pair ports with operand fields it takes from the instruction. For the operation that multiplies the two halves of one source word, the 64-bit addend comes from the pair named by the first source field. The sum goes to the pair named by the destination field, which may be a different pair. For every other accumulate operation, the destination field names both the addend pair and the pair that is written back. The file leaves that routing to the caller.

All reads are combinational. The pair write takes effect at one clock edge. The ports carry no valid/ready handshake, because a register file never applies back-pressure. A read is answered in the same cycle, and a write always lands at the next edge.

Top module: `pair_regfile`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted, every register is cleared to zero. After reset, every plain read and every pair read returns zero.
- R2: A pair read port returns {register 2d+1, register 2d} in the same cycle, with d equal to bits 4:1 of its select field. The odd register appears in bits 63:32 and the even register in bits 31:0.
- R3: Bit 0 of a pair select field is ignored. Field values 2k and 2k+1 return the same 64-bit value.
- R4: When the write enable is high at a rising edge, bits 31:0 of the write value go into register 2d and bits 63:32 into register 2d+1 at that same edge. Here d is bits 4:1 of the write field. From the next cycle on, reads of either register show both new halves.
- R5: A pair read made in the same cycle as a pair write to the same pair returns the value from before the write.
- R6: Register 0 always reads as zero. A pair write to pair 0 changes only register 1.
- R7: A plain read port returns the register named by its 5-bit address in the same cycle.
- R8: When the write enable is low, no register changes, whatever the write field and write value are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pa_sel | input | 5 | Register field for pair read port A (bits 4:1 used) |
| pa_data | output | 64 | Pair read data A |
| pb_sel | input | 5 | Register field for pair read port B (bits 4:1 used) |
| pb_data | output | 64 | Pair read data B |
| pw_en | input | 1 | Pair write enable |
| pw_sel | input | 5 | Register field for the pair write (bits 4:1 used) |
| pw_data | input | 64 | Pair write value |
| ra_addr | input | 5 | Plain read address A |
| ra_data | output | 32 | Plain read data A |
| rb_addr | input | 5 | Plain read address B |
| rb_data | output | 32 | Plain read data B |

## Verification
Read results are due in the cycle in which their address or select is applied. The bench therefore drives the selects on the falling edge and samples the outputs one time unit later, before the next rising edge. A pair write is due one edge later. The bench applies it at the falling edge, lets a single rising edge pass, and then checks the new contents. For the same-cycle read-and-write case it samples before that edge to see the old value and after the edge to see the new one. The bench's expected values come from a 32-entry model that it updates only after each write edge.

// File: rtl/pair_rf_pkg.sv
package pair_rf_pkg;
  localparam int unsigned DEF_NREGS  = 32;
  localparam int unsigned DEF_WORD_W = 32;

  // which half of a pair a register index carries
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  function automatic half_e half_of(input int unsigned idx);
    return (idx % 2 == 1) ? HALF_HI : HALF_LO;
  endfunction
endpackage

// File: rtl/pair_rf_store.sv
module pair_rf_store
  import pair_rf_pkg::*;
#(
  parameter int unsigned NREGS  = DEF_NREGS,
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned AW     = $clog2(NREGS),
  localparam int unsigned PAIR_W = AW - 1,
  localparam int unsigned DW     = 2 * WORD_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [PAIR_W-1:0]              wr_pair,
  input  logic [DW-1:0]                  wr_data,
  output logic [NREGS-1:0][WORD_W-1:0]   mem_q
);
  logic [NREGS-1:0]             we;
  logic [NREGS-1:0][WORD_W-1:0] wval;

  for (genvar i = 0; i < NREGS; i++) begin : g_lane
    if (i == 0) begin : g_zero
      assign we[i]   = 1'b0;
      assign wval[i] = '0;
    end else begin : g_live
      assign we[i] = wr_en && (wr_pair == PAIR_W'(i / 2));
      if (half_of(i) == HALF_HI) begin : g_hi
        assign wval[i] = wr_data[DW-1:WORD_W];
      end else begin : g_lo
        assign wval[i] = wr_data[WORD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (we[i]) mem_q[i] <= wval[i];
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> mem_q == '0);

  p_hi_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[{$past(wr_pair), 1'b1}] == $past(wr_data[DW-1:WORD_W]));

  p_lo_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pair != '0) |=> mem_q[{$past(wr_pair), 1'b0}] == $past(wr_data[WORD_W-1:0]));

  p_reg0_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_q[0] == '0);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));
endmodule

// File: rtl/pair_rf_pair_rd.sv
module pair_rf_pair_rd #(
  parameter int unsigned NREGS  = 32,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned AW     = $clog2(NREGS),
  localparam int unsigned PAIR_W = AW - 1
) (
  input  logic [NREGS-1:0][WORD_W-1:0] mem_q,
  input  logic [AW-1:0]                sel,
  output logic [2*WORD_W-1:0]          data
);
  logic [PAIR_W-1:0] pair;
  logic              unused_sel_bit0;

  assign pair            = sel[AW-1:1];
  assign unused_sel_bit0 = sel[0];
  assign data            = {mem_q[{pair, 1'b1}], mem_q[{pair, 1'b0}]};
endmodule

// File: rtl/pair_rf_word_rd.sv
module pair_rf_word_rd #(
  parameter int unsigned NREGS  = 32,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned AW     = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][WORD_W-1:0] mem_q,
  input  logic [AW-1:0]                addr,
  output logic [WORD_W-1:0]            data
);
  assign data = mem_q[addr];
endmodule

// File: rtl/pair_regfile.sv
module pair_regfile
  import pair_rf_pkg::*;
#(
  parameter int unsigned NREGS  = DEF_NREGS,
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned AW     = $clog2(NREGS),
  localparam int unsigned DW     = 2 * WORD_W,
  localparam int unsigned NPRD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     pa_sel,
  output logic [DW-1:0]     pa_data,
  input  logic [AW-1:0]     pb_sel,
  output logic [DW-1:0]     pb_data,
  input  logic              pw_en,
  input  logic [AW-1:0]     pw_sel,
  input  logic [DW-1:0]     pw_data,
  input  logic [AW-1:0]     ra_addr,
  output logic [WORD_W-1:0] ra_data,
  input  logic [AW-1:0]     rb_addr,
  output logic [WORD_W-1:0] rb_data
);
  logic [NREGS-1:0][WORD_W-1:0] mem_q;
  logic [AW-1:0]                psel [NPRD];
  logic [DW-1:0]                pdat [NPRD];
  logic [AW-1:0]                wsel [NPRD];
  logic [WORD_W-1:0]            wdat [NPRD];
  logic                         unused_pw_bit0;

  assign unused_pw_bit0 = pw_sel[0];

  pair_rf_store #(.NREGS(NREGS), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pw_en),
    .wr_pair (pw_sel[AW-1:1]),
    .wr_data (pw_data),
    .mem_q   (mem_q)
  );

  assign psel[0] = pa_sel;
  assign psel[1] = pb_sel;
  assign wsel[0] = ra_addr;
  assign wsel[1] = rb_addr;

  for (genvar p = 0; p < NPRD; p++) begin : g_rd
    pair_rf_pair_rd #(.NREGS(NREGS), .WORD_W(WORD_W)) u_prd (
      .mem_q (mem_q),
      .sel   (psel[p]),
      .data  (pdat[p])
    );
    pair_rf_word_rd #(.NREGS(NREGS), .WORD_W(WORD_W)) u_wrd (
      .mem_q (mem_q),
      .addr  (wsel[p]),
      .data  (wdat[p])
    );
  end

  assign pa_data = pdat[0];
  assign pb_data = pdat[1];
  assign ra_data = wdat[0];
  assign rb_data = wdat[1];

  p_same_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_sel[AW-1:1] == pb_sel[AW-1:1]) |-> pa_data == pb_data);

  p_hi_matches_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_addr == {pa_sel[AW-1:1], 1'b1}) |-> pa_data[DW-1:WORD_W] == ra_data);

  p_lo_matches_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_addr == {pb_sel[AW-1:1], 1'b0}) |-> pb_data[WORD_W-1:0] == rb_data);

  p_word0_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_addr == '0) |-> ra_data == '0);
endmodule

// File: tb/tb_pair_regfile.sv
module tb_pair_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  pa_sel, pb_sel, pw_sel, ra_addr, rb_addr;
  logic        pw_en;
  logic [63:0] pw_data;
  logic [63:0] pa_data, pb_data;
  logic [31:0] ra_data, rb_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .pa_sel(pa_sel), .pa_data(pa_data),
    .pb_sel(pb_sel), .pb_data(pb_data),
    .pw_en(pw_en), .pw_sel(pw_sel), .pw_data(pw_data),
    .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data)
  );

  function automatic logic [63:0] exp_pair(input logic [4:0] sel);
    return {model[{sel[4:1], 1'b1}], model[{sel[4:1], 1'b0}]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [4:0] sel, input logic [63:0] val);
    if (sel[4:1] != 4'd0) model[{sel[4:1], 1'b0}] = val[31:0];
    model[{sel[4:1], 1'b1}] = val[63:32];
  endtask

  task automatic pair_write(input logic [4:0] sel, input logic [63:0] val);
    @(negedge clk);
    pw_sel = sel; pw_data = val; pw_en = 1'b1;
    @(posedge clk);
    #1;
    pw_en = 1'b0;
    model_write(sel, val);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ra_addr = 5'(i); rb_addr = 5'(i); pa_sel = 5'(i); pb_sel = 5'(i ^ 1);
      #1;
      chk({tag, " R7 word A"}, {32'd0, ra_data}, {32'd0, model[i]});
      chk({tag, " R7 word B"}, {32'd0, rb_data}, {32'd0, model[i]});
      chk({tag, " R2 pair A"}, pa_data, exp_pair(5'(i)));
      chk({tag, " R3 pair B bit0 flipped"}, pb_data, exp_pair(5'(i)));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned sink;
    logic [63:0] oldv, newv;
    sink = $urandom(32'd2024);
    for (int i = 0; i < 32; i++) model[i] = '0;
    rst_n = 1'b0; pw_en = 1'b0; pw_sel = '0; pw_data = '0;
    pa_sel = '0; pb_sel = '0; ra_addr = '0; rb_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    sweep("R1 reset");

    // R4 directed: field 6 -> regs 6/7, read back through field 7 (R3)
    pair_write(5'd6, 64'hCAFE_0001_BEEF_0002);
    @(negedge clk);
    ra_addr = 5'd6; rb_addr = 5'd7; pa_sel = 5'd7; pb_sel = 5'd6;
    #1;
    chk("R4 even reg low half", {32'd0, ra_data}, 64'h0000_0000_BEEF_0002);
    chk("R4 odd reg high half", {32'd0, rb_data}, 64'h0000_0000_CAFE_0001);
    chk("R3 odd field same pair", pa_data, 64'hCAFE_0001_BEEF_0002);
    chk("R2 even field", pb_data, 64'hCAFE_0001_BEEF_0002);

    // R6: pair 0 write via field 1 touches only register 1
    pair_write(5'd1, 64'h1234_5678_FFFF_FFFF);
    @(negedge clk);
    ra_addr = 5'd0; rb_addr = 5'd1; pa_sel = 5'd0;
    #1;
    chk("R6 reg0 stays zero", {32'd0, ra_data}, 64'd0);
    chk("R6 reg1 written", {32'd0, rb_data}, 64'h0000_0000_1234_5678);
    chk("R6 pair0 read", pa_data, 64'h1234_5678_0000_0000);

    // R5: read-before-write on the same pair
    pair_write(5'd10, 64'h1111_2222_3333_4444);
    oldv = 64'h1111_2222_3333_4444;
    newv = 64'h5555_6666_7777_8888;
    @(negedge clk);
    pa_sel = 5'd10; pb_sel = 5'd11; pw_sel = 5'd11; pw_data = newv; pw_en = 1'b1;
    #1;
    chk("R5 same-cycle read old A", pa_data, oldv);
    chk("R5 same-cycle read old B", pb_data, oldv);
    @(posedge clk);
    #1;
    pw_en = 1'b0;
    model_write(5'd11, newv);
    chk("R5 next cycle new value", pa_data, newv);

    // R8: enable low leaves contents alone
    @(negedge clk);
    pw_sel = 5'd10; pw_data = 64'hDEAD_DEAD_DEAD_DEAD; pw_en = 1'b0;
    @(posedge clk);
    #1;
    ra_addr = 5'd10; rb_addr = 5'd11; pa_sel = 5'd10;
    #1;
    chk("R8 even unchanged", {32'd0, ra_data}, {32'd0, newv[31:0]});
    chk("R8 odd unchanged", {32'd0, rb_data}, {32'd0, newv[63:32]});
    chk("R8 pair unchanged", pa_data, newv);

    // top pair 15 (regs 30/31)
    pair_write(5'd31, 64'h8000_0000_7FFF_FFFF);
    @(negedge clk);
    pa_sel = 5'd30; ra_addr = 5'd31; rb_addr = 5'd30;
    #1;
    chk("R4 top pair", pa_data, 64'h8000_0000_7FFF_FFFF);
    chk("R4 reg31", {32'd0, ra_data}, 64'h0000_0000_8000_0000);
    chk("R4 reg30", {32'd0, rb_data}, 64'h0000_0000_7FFF_FFFF);

    // random mix: checks before each edge, model updated after it
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      pa_sel = 5'($urandom); pb_sel = 5'($urandom);
      ra_addr = 5'($urandom); rb_addr = 5'($urandom);
      pw_sel = 5'($urandom); pw_data = {$urandom, $urandom};
      pw_en = ($urandom % 3) != 0;
      #1;
      chk("R2 random pair A", pa_data, exp_pair(pa_sel));
      chk("R2 random pair B", pb_data, exp_pair(pb_sel));
      chk("R7 random word A", {32'd0, ra_data}, {32'd0, model[ra_addr]});
      chk("R7 random word B", {32'd0, rb_data}, {32'd0, model[rb_addr]});
      @(posedge clk);
      #1;
      if (pw_en) model_write(pw_sel, pw_data);
    end
    @(negedge clk);
    pw_en = 1'b0;

    sweep("R4 final");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule